// File: doc/BRIEF.md
# Atomic Fetch-and-Add Counter Bank

This block holds a 2048-byte bank of shared counters. Several requesters reach it at once, and every operation on the bank is atomic. An operand is 8, 16, 32 or 64 bits wide. The bank stores each 64-bit word with its most significant byte first.

There are three request kinds:
- A fetch request carries its register index, a signed 22-bit increment and a wait flag inside the 64-bit request address. It returns the operand value from before the update.
- A store request adds its store data to the operand or overwrites the operand. Address bit 13 chooses which.
- An asynchronous request is a fetch-and-add whose old value goes to a scratchpad word instead of the response port.

Each requester owns one holding slot. A request that sets the wait flag stays in its slot until that requester's tag-done input goes high, or until a fixed number of cycles has passed. A wait that runs out reports an error in bit 63 and leaves the bank unchanged. While one requester waits, the other requesters are still served.

Top module: `atomic_add_unit`

## Requirements
- R1: After reset, every bank byte reads zero, all `req_ready` bits are high, and `resp_valid`, `spad_we` and `misalign_err` are low.
- R2: A fetch request (`req_kind` 0) reads the operand, writes back old plus the increment modulo the operand width, and returns the old value zero-extended in `resp_data`. The increment is address bits 35:14, taken as a signed value. A non-waiting request accepted at one clock edge with no contention raises `resp_valid` for its requester after the second edge.
- R3: The operand size code is 0/1/2/3 for 8/16/32/64 bits, and the register index is address bits 10:0. Byte index i holds bits 63-8*(i mod 8) down to 56-8*(i mod 8) of word i/8, so the lowest index of an operand is its most significant byte. An update changes no other byte of the word.
- R4: A store request (`req_kind` 1) with address bit 13 clear adds the low operand-width bits of `req_data` to the operand, wrapping modulo the width. It produces no response.
- R5: A store request with address bit 13 set overwrites the operand with the low operand-width bits of `req_data`.
- R6: An asynchronous request (`req_kind` 2) takes its size from bits 12:11 and its scratchpad word address from bits 63:56. It does a fetch-and-add and writes the old value through `spad_we`/`spad_addr`/`spad_data`, with no `resp_valid`.
- R7: A fetch or asynchronous request with address bit 13 set is held until its requester's `tag_done` is high. It then executes as in R2 or R6, and bit 63 of its result is cleared.
- R8: If `tag_done` stays low, a waiting request executes as a timeout. When accepted at edge E0 with no contention, its result appears after edge E0+WAIT_LIMIT+1. The result is exactly bit 63 set, and the bank is not changed.
- R9: A requester whose request is waiting does not delay requests from other requesters.
- R10: Requests that become ready in the same cycle are served one per cycle, the lowest requester index first. Every update is applied, so none is lost.
- R11: An index that is not a multiple of the operand byte width leaves the bank unchanged and returns zero. It also sets `misalign_err`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_REQ | Request present, one bit per requester |
| req_ready | output | NUM_REQ | Slot of the requester is free |
| req_kind | input | 2*NUM_REQ | Request kind per requester: 0 fetch, 1 store, 2 asynchronous |
| req_size | input | 2*NUM_REQ | Operand size code for fetch and store requests |
| req_addr | input | 64*NUM_REQ | Request address or asynchronous command word |
| req_data | input | 64*NUM_REQ | Store data |
| tag_done | input | NUM_REQ | Pending tag switch of the requester has completed |
| resp_valid | output | NUM_REQ | Fetch result for that requester is on `resp_data` |
| resp_data | output | 64 | Fetch result |
| spad_we | output | 1 | Scratchpad word write |
| spad_addr | output | 8 | Scratchpad word address |
| spad_data | output | 64 | Scratchpad write data |
| misalign_err | output | 1 | Sticky misaligned-index flag |

## Verification
The bench builds the block with two requesters and WAIT_LIMIT set to 16, keeping the full 2048-byte bank. The short wait limit brings the timeout path into reach within a few dozen cycles, so its exact latency can be checked. Two requesters are enough to exercise same-cycle arbitration on one counter and one requester waiting while the other is served. The random operations are confined to the low 64 bytes, so different sizes keep landing on the same words and the lane placement is checked against a byte-wise model.

// File: rtl/fau_pkg.sv
// Shared encodings for the atomic fetch-and-add counter bank.
// Assumes the 64-bit request word layout used by all requesters.
package fau_pkg;
    typedef enum logic [1:0] {
        OP_FETCH = 2'd0,
        OP_STORE = 2'd1,
        OP_ASYNC = 2'd2
    } op_kind_e;

    localparam int INC_LO   = 14;
    localparam int INC_HI   = 35;
    localparam int FLAG_BIT = 13;   // wait flag (fetch/async) or overwrite (store)
    localparam int SIZE_LO  = 11;
    localparam int SPAD_LO  = 56;
endpackage

// File: rtl/fau_slot.sv
// Per-requester holding slot. It takes one request when free and holds it
// until the arbiter grants it. A waiting request becomes eligible when
// tag_done rises or when its cycle counter reaches WAIT_LIMIT.
// Assumes the grant arrives only while eligible is high.
module fau_slot #(
    parameter int WAIT_LIMIT = 1024,
    localparam int CW = $clog2(WAIT_LIMIT + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [1:0]  in_kind,
    input  logic [1:0]  in_size,
    input  logic [63:0] in_addr,
    input  logic [63:0] in_data,
    input  logic        tag_done,
    input  logic        grant,
    output logic        ready,
    output logic        eligible,
    output logic        timed_out,
    output logic [1:0]  q_kind,
    output logic [1:0]  q_size,
    output logic [63:0] q_addr,
    output logic [63:0] q_data
);
    import fau_pkg::*;

    localparam logic [CW-1:0] LIMIT_V = CW'(WAIT_LIMIT);

    logic          busy;
    logic [CW-1:0] cnt;
    logic          waiting;
    logic          expired;

    assign waiting   = busy && (q_kind != OP_STORE) && q_addr[FLAG_BIT];
    assign expired   = (cnt == LIMIT_V);
    assign ready     = !busy;
    assign eligible  = busy && (!waiting || tag_done || expired);
    assign timed_out = waiting && !tag_done && expired;

    // Load a new request, release on grant, count cycles spent waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            q_kind <= '0;
            q_size <= '0;
            q_addr <= '0;
            q_data <= '0;
        end else if (!busy) begin
            if (in_valid) begin
                busy   <= 1'b1;
                cnt    <= '0;
                q_kind <= in_kind;
                q_size <= in_size;
                q_addr <= in_addr;
                q_data <= in_data;
            end
        end else if (grant) begin
            busy <= 1'b0;
        end else if (waiting && !tag_done && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_HOLD_UNTIL_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !grant |=> busy && $stable(q_addr));  // R10
    AST_WAIT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && !tag_done && !expired |-> !grant);  // R7
endmodule

// File: rtl/fau_arbiter.sv
// Fixed-priority arbiter: grants the lowest-index eligible slot each cycle.
// Assumes eligible inputs are stable within the cycle.
module fau_arbiter #(
    parameter int NUM_REQ = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] elig,
    output logic [NUM_REQ-1:0] grant
);
    // Pick the first eligible index from bit 0 upward.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (elig[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));  // R10
    AST_GRANT_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        (|elig) |-> (|grant));  // R9
endmodule

// File: rtl/fau_datapath.sv
// Counter bank plus single-cycle read-modify-write for the granted request.
// Words are big-endian: the lowest byte index is the most significant lane.
// Registers the fetch response, the scratchpad write and the sticky error.
module fau_datapath #(
    parameter int NUM_REQ    = 2,
    parameter int BANK_BYTES = 2048,
    localparam int WORDS = BANK_BYTES / 8,
    localparam int IDXW  = $clog2(BANK_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] grant,
    input  logic [1:0]         kind,
    input  logic [1:0]         size,
    input  logic [63:0]        addr,
    input  logic [63:0]        data,
    input  logic               timeout,
    output logic [NUM_REQ-1:0] resp_valid,
    output logic [63:0]        resp_data,
    output logic               spad_we,
    output logic [7:0]         spad_addr,
    output logic [63:0]        spad_data,
    output logic               misalign_err
);
    import fau_pkg::*;

    logic [63:0]      mem [WORDS];
    logic             go;
    logic             is_store, is_async, waited, misal, wr_en;
    logic [1:0]       sz;
    logic [IDXW-1:0]  idx;
    logic [IDXW-4:0]  word;
    logic [2:0]       off;
    logic [3:0]       nbytes, lanepos;
    logic [5:0]       shamt;
    logic [63:0]      wmask, oldw, old_op, inc, nv, neww, result;
    logic             unused_bits;

    assign unused_bits = ^addr[55:36];
    assign go = |grant;

    // Decode the request, extract the lane, form the new word and result.
    always_comb begin
        is_store = (kind == OP_STORE);
        is_async = (kind == OP_ASYNC);
        sz       = is_async ? addr[SIZE_LO+1:SIZE_LO] : size;
        idx      = addr[IDXW-1:0];
        word     = idx[IDXW-1:3];
        off      = idx[2:0];
        nbytes   = 4'd1 << sz;
        lanepos  = 4'd8 - {1'b0, off} - nbytes;
        shamt    = {lanepos[2:0], 3'b000};
        case (sz)
            2'd0:    wmask = 64'h0000_0000_0000_00FF;
            2'd1:    wmask = 64'h0000_0000_0000_FFFF;
            2'd2:    wmask = 64'h0000_0000_FFFF_FFFF;
            default: wmask = '1;
        endcase
        misal  = ({1'b0, off} & (nbytes - 4'd1)) != 4'd0;
        waited = !is_store && addr[FLAG_BIT];
        oldw   = mem[word];
        old_op = (oldw >> shamt) & wmask;
        inc    = is_store ? data : {{42{addr[INC_HI]}}, addr[INC_HI:INC_LO]};
        nv     = ((is_store && addr[FLAG_BIT]) ? data : (old_op + inc)) & wmask;
        neww   = (oldw & ~(wmask << shamt)) | (nv << shamt);
        wr_en  = !misal && !timeout;
        if (misal)        result = '0;
        else if (timeout) result = 64'h8000_0000_0000_0000;
        else if (waited)  result = {1'b0, old_op[62:0]};
        else              result = old_op;
    end

    // Bank storage: clear on reset, write back the updated word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (go && wr_en) begin
            mem[word] <= neww;
        end
    end

    // Register the fetch response and the scratchpad write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= '0;
            resp_data  <= '0;
            spad_we    <= 1'b0;
            spad_addr  <= '0;
            spad_data  <= '0;
        end else begin
            resp_valid <= (go && !is_store && !is_async) ? grant : '0;
            resp_data  <= result;
            spad_we    <= go && is_async;
            spad_addr  <= addr[SPAD_LO+7:SPAD_LO];
            spad_data  <= result;
        end
    end

    // Sticky misaligned-index flag.
    always_ff @(posedge clk) begin
        if (!rst_n)            misalign_err <= 1'b0;
        else if (go && misal)  misalign_err <= 1'b1;
    end

    AST_RESP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resp_valid, spad_we}));  // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_err |=> misalign_err);  // R11
endmodule

// File: rtl/atomic_add_unit.sv
// Top of the atomic fetch-and-add counter bank. It has one holding slot per
// requester, a fixed-priority arbiter and a single-cycle datapath. Assumes each
// requester keeps req_valid high until req_ready shows the request was taken.
module atomic_add_unit #(
    parameter int NUM_REQ    = 2,
    parameter int BANK_BYTES = 2048,
    parameter int WAIT_LIMIT = 1024
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_REQ-1:0]      req_valid,
    output logic [NUM_REQ-1:0]      req_ready,
    input  logic [2*NUM_REQ-1:0]    req_kind,
    input  logic [2*NUM_REQ-1:0]    req_size,
    input  logic [64*NUM_REQ-1:0]   req_addr,
    input  logic [64*NUM_REQ-1:0]   req_data,
    input  logic [NUM_REQ-1:0]      tag_done,
    output logic [NUM_REQ-1:0]      resp_valid,
    output logic [63:0]             resp_data,
    output logic                    spad_we,
    output logic [7:0]              spad_addr,
    output logic [63:0]             spad_data,
    output logic                    misalign_err
);
    logic [NUM_REQ-1:0] elig, tmo, grant;
    logic [1:0]         s_kind [NUM_REQ];
    logic [1:0]         s_size [NUM_REQ];
    logic [63:0]        s_addr [NUM_REQ];
    logic [63:0]        s_data [NUM_REQ];
    logic [1:0]         sel_kind, sel_size;
    logic [63:0]        sel_addr, sel_data;
    logic               sel_tmo;

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_slot
        fau_slot #(.WAIT_LIMIT(WAIT_LIMIT)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (req_valid[g]),
            .in_kind   (req_kind[2*g +: 2]),
            .in_size   (req_size[2*g +: 2]),
            .in_addr   (req_addr[64*g +: 64]),
            .in_data   (req_data[64*g +: 64]),
            .tag_done  (tag_done[g]),
            .grant     (grant[g]),
            .ready     (req_ready[g]),
            .eligible  (elig[g]),
            .timed_out (tmo[g]),
            .q_kind    (s_kind[g]),
            .q_size    (s_size[g]),
            .q_addr    (s_addr[g]),
            .q_data    (s_data[g])
        );
    end

    fau_arbiter #(.NUM_REQ(NUM_REQ)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig),
        .grant (grant)
    );

    // Route the granted slot's request to the datapath.
    always_comb begin
        sel_kind = '0;
        sel_size = '0;
        sel_addr = '0;
        sel_data = '0;
        sel_tmo  = 1'b0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (grant[i]) begin
                sel_kind = s_kind[i];
                sel_size = s_size[i];
                sel_addr = s_addr[i];
                sel_data = s_data[i];
                sel_tmo  = tmo[i];
            end
        end
    end

    fau_datapath #(.NUM_REQ(NUM_REQ), .BANK_BYTES(BANK_BYTES)) u_dp (
        .clk          (clk),
        .rst_n        (rst_n),
        .grant        (grant),
        .kind         (sel_kind),
        .size         (sel_size),
        .addr         (sel_addr),
        .data         (sel_data),
        .timeout      (sel_tmo),
        .resp_valid   (resp_valid),
        .resp_data    (resp_data),
        .spad_we      (spad_we),
        .spad_addr    (spad_addr),
        .spad_data    (spad_data),
        .misalign_err (misalign_err)
    );
endmodule

// File: tb/atomic_add_unit_bench.sv
`timescale 1ns/1ps
module atomic_add_unit_bench;
    localparam int N  = 2;
    localparam int WL = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      req_valid = '0;
    logic [N-1:0]      req_ready;
    logic [2*N-1:0]    req_kind = '0;
    logic [2*N-1:0]    req_size = '0;
    logic [64*N-1:0]   req_addr = '0;
    logic [64*N-1:0]   req_data = '0;
    logic [N-1:0]      tag_done = '0;
    logic [N-1:0]      resp_valid;
    logic [63:0]       resp_data;
    logic              spad_we;
    logic [7:0]        spad_addr;
    logic [63:0]       spad_data;
    logic              misalign_err;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] shadow [0:2047];

    always #4 clk = ~clk;

    atomic_add_unit #(.NUM_REQ(N), .BANK_BYTES(2048), .WAIT_LIMIT(WL)) u_atomic_add_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_size(req_size), .req_addr(req_addr),
        .req_data(req_data), .tag_done(tag_done), .resp_valid(resp_valid),
        .resp_data(resp_data), .spad_we(spad_we), .spad_addr(spad_addr),
        .spad_data(spad_data), .misalign_err(misalign_err)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] fetch_addr(input int idx, input logic [21:0] inc, input bit w);
        logic [63:0] a = '0;
        a[35:14] = inc; a[13] = w; a[10:0] = idx[10:0];
        return a;
    endfunction

    function automatic logic [63:0] store_addr(input int idx, input bit ovw);
        logic [63:0] a = '0;
        a[13] = ovw; a[10:0] = idx[10:0];
        return a;
    endfunction

    function automatic logic [63:0] async_addr(input logic [7:0] sp, input int sz, input int idx,
                                               input logic [21:0] inc, input bit w);
        logic [63:0] a = '0;
        a[63:56] = sp; a[55:48] = 8'd1; a[35:14] = inc; a[13] = w;
        a[12:11] = sz[1:0]; a[10:0] = idx[10:0];
        return a;
    endfunction

    // Byte-wise big-endian reference model of one operation.
    task automatic model_exec(input int kind, input int sz, input logic [63:0] a,
                              input logic [63:0] d, input bit tmo, output logic [63:0] res);
        int idx = int'(a[10:0]);
        int w = 1 << sz;
        logic [63:0] old = '0;
        logic [63:0] msk, inc, nv;
        msk = (sz == 3) ? '1 : ((64'd1 << (8 * w)) - 1);
        if (idx % w != 0) begin res = '0; return; end
        for (int b = 0; b < w; b++) old = (old << 8) | 64'(shadow[idx + b]);
        if (tmo) begin res = 64'h8000_0000_0000_0000; return; end
        inc = (kind == 1) ? d : {{42{a[35]}}, a[35:14]};
        nv  = (((kind == 1) && a[13]) ? d : (old + inc)) & msk;
        for (int b = w - 1; b >= 0; b--) begin
            shadow[idx + b] = nv[7:0];
            nv = nv >> 8;
        end
        res = old;
        if (kind != 1 && a[13]) res[63] = 1'b0;
    endtask

    task automatic drive(input int r, input int kind, input int sz, input logic [63:0] a, input logic [63:0] d);
        req_valid[r] = 1'b1;
        req_kind[r*2 +: 2] = kind[1:0];
        req_size[r*2 +: 2] = sz[1:0];
        req_addr[r*64 +: 64] = a;
        req_data[r*64 +: 64] = d;
    endtask

    task automatic run_op(input int r, input int kind, input int sz, input logic [63:0] a,
                          input logic [63:0] d, input bit tmo, input string tag, output int lat);
        logic [63:0] exp;
        bit got = 0;
        int cyc = 0;
        model_exec(kind, (kind == 2) ? int'(a[12:11]) : sz, a, d, tmo, exp);
        @(negedge clk);
        while (!req_ready[r]) @(negedge clk);
        drive(r, kind, sz, a, d);
        while (!got && cyc < WL + 20) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) req_valid[r] = 1'b0;
            if (kind == 1) begin
                if (cyc == 3) got = 1;
            end else if (kind == 2) begin
                if (spad_we) begin
                    got = 1;
                    check(spad_addr == a[63:56] && spad_data == exp && resp_valid == '0,
                          {tag, " R6 async"}, spad_data, exp);
                end
            end else if (resp_valid[r]) begin
                got = 1;
                check(resp_data == exp, {tag, " R2 fetch"}, resp_data, exp);
            end
        end
        lat = cyc;
        if (!got) check(1'b0, {tag, " no response"}, 64'd0, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lat;
        logic [63:0] e0, e1;
        void'($urandom(32'd4242));
        for (int i = 0; i < 2048; i++) shadow[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(req_ready == '1 && resp_valid == '0 && !spad_we && !misalign_err,
              "R1 reset outputs", {58'd0, req_ready, resp_valid, spad_we, misalign_err}, {58'd0, 2'b11, 4'b0});
        run_op(0, 0, 3, fetch_addr(0, 22'd0, 0), 0, 0, "R1 zero bank", lat);
        run_op(1, 0, 3, fetch_addr(2040, 22'd0, 0), 0, 0, "R1 zero bank top", lat);

        // R2 latency and negative increment
        run_op(0, 0, 2, fetch_addr(4, 22'd7, 0), 0, 0, "R2 add", lat);
        check(lat == 2, "R2 latency", 64'(lat), 64'd2);
        run_op(0, 0, 2, fetch_addr(4, -22'sd10, 0), 0, 0, "R2 negative inc", lat);
        run_op(0, 0, 2, fetch_addr(4, 22'd0, 0), 0, 0, "R2 wrap readback", lat);

        // R3 lane placement, R5 overwrite, R4 store add
        run_op(0, 1, 3, store_addr(16, 1), 64'h0102_0304_0506_0708, 0, "R5 overwrite", lat);
        run_op(0, 0, 0, fetch_addr(16, 22'd0, 0), 0, 0, "R3 byte0", lat);
        check(resp_data == 64'h01, "R3 msb lane", resp_data, 64'h01);
        run_op(0, 0, 0, fetch_addr(23, 22'd0, 0), 0, 0, "R3 byte7", lat);
        check(resp_data == 64'h08, "R3 lsb lane", resp_data, 64'h08);
        run_op(1, 0, 1, fetch_addr(18, 22'd0, 0), 0, 0, "R3 half", lat);
        run_op(1, 0, 2, fetch_addr(20, 22'd0, 0), 0, 0, "R3 word", lat);
        run_op(0, 1, 0, store_addr(17, 0), 64'h0000_0000_0000_01FF, 0, "R4 store add wrap", lat);
        run_op(0, 0, 3, fetch_addr(16, 22'd0, 0), 0, 0, "R3 neighbours", lat);
        check(resp_data == 64'h0101_0304_0506_0708, "R4 byte wrap untouched neighbours",
              resp_data, 64'h0101_0304_0506_0708);

        // R6 async
        run_op(1, 2, 0, async_addr(8'h5A, 2, 20, 22'd3, 0), 0, 0, "R6", lat);
        run_op(0, 0, 2, fetch_addr(20, 22'd0, 0), 0, 0, "R6 update", lat);

        // Random mix, aligned, low 64 bytes
        for (int i = 0; i < 300; i++) begin
            int kind = $urandom % 3;
            int sz = $urandom % 4;
            int idx = ($urandom % 64) & ~((1 << sz) - 1);
            int r = $urandom % 2;
            logic [21:0] inc = 22'($urandom);
            logic [63:0] d = {$urandom, $urandom};
            logic [63:0] a;
            if (kind == 0) a = fetch_addr(idx, inc, 0);
            else if (kind == 1) a = store_addr(idx, 1'($urandom));
            else a = async_addr(8'($urandom), sz, idx, inc, 0);
            run_op(r, kind, sz, a, d, 0, "R2/R4/R5/R6 random", lat);
        end
        check(!misalign_err, "R11 flag quiet while aligned", {63'd0, misalign_err}, 64'd0);

        // R7 wait then tag_done, with bit 63 of the old value set
        run_op(0, 1, 3, store_addr(8, 1), 64'h8000_0000_0000_0005, 0, "R7 setup", lat);
        model_exec(0, 3, fetch_addr(8, 22'd1, 1), 0, 0, e0);
        @(negedge clk);
        drive(0, 0, 3, fetch_addr(8, 22'd1, 1), 0);
        @(negedge clk);
        req_valid[0] = 1'b0;
        repeat (6) @(negedge clk);
        check(resp_valid == '0, "R7 held while tag pending", {62'd0, resp_valid}, 64'd0);
        tag_done[0] = 1'b1;
        @(negedge clk);
        check(resp_valid == 2'b01 && resp_data == e0, "R7 released result", resp_data, e0);
        tag_done[0] = 1'b0;
        run_op(0, 0, 3, fetch_addr(8, 22'd0, 0), 0, 0, "R7 update", lat);

        // R8 timeout
        run_op(0, 0, 3, fetch_addr(24, 22'd9, 1), 0, 1, "R8 timeout", lat);
        check(lat == WL + 2, "R8 timeout latency", 64'(lat), 64'(WL + 2));
        run_op(0, 0, 3, fetch_addr(24, 22'd0, 0), 0, 0, "R8 bank unchanged", lat);

        // R9 waiting requester does not block another
        @(negedge clk);
        drive(0, 0, 2, fetch_addr(48, 22'd9, 1), 0);
        @(negedge clk);
        req_valid[0] = 1'b0;
        run_op(1, 0, 2, fetch_addr(56, 22'd4, 0), 0, 0, "R9 other served", lat);
        check(lat == 2, "R9 other latency", 64'(lat), 64'd2);
        check(resp_valid[0] == 1'b0, "R9 waiter still held", {63'd0, resp_valid[0]}, 64'd0);
        model_exec(0, 2, fetch_addr(48, 22'd9, 1), 0, 0, e0);
        tag_done[0] = 1'b1;
        @(negedge clk);
        check(resp_valid == 2'b01 && resp_data == e0, "R9 waiter result", resp_data, e0);
        tag_done[0] = 1'b0;

        // R10 same-cycle requests on one counter
        model_exec(0, 2, fetch_addr(40, 22'd5, 0), 0, 0, e0);
        model_exec(0, 2, fetch_addr(40, 22'd7, 0), 0, 0, e1);
        @(negedge clk);
        drive(0, 0, 2, fetch_addr(40, 22'd5, 0), 0);
        drive(1, 0, 2, fetch_addr(40, 22'd7, 0), 0);
        @(negedge clk);
        req_valid = '0;
        check(resp_valid == '0, "R10 nothing yet", {62'd0, resp_valid}, 64'd0);
        @(negedge clk);
        check(resp_valid == 2'b01 && resp_data == e0, "R10 low index first", resp_data, e0);
        @(negedge clk);
        check(resp_valid == 2'b10 && resp_data == e1, "R10 second sees first update", resp_data, e1);
        run_op(0, 0, 2, fetch_addr(40, 22'd0, 0), 0, 0, "R10 both applied", lat);

        // R11 misaligned
        run_op(0, 0, 2, fetch_addr(34, 22'd1, 0), 0, 0, "R11 misaligned fetch", lat);
        check(resp_data == 64'd0, "R11 zero result", resp_data, 64'd0);
        check(misalign_err, "R11 flag set", {63'd0, misalign_err}, 64'd1);
        run_op(1, 0, 3, fetch_addr(32, 22'd0, 0), 0, 0, "R11 bank unchanged", lat);
        check(misalign_err, "R11 flag sticky", {63'd0, misalign_err}, 64'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule